// File: doc/BRIEF.md
# Monitor Channel Handshake Transmitter

This block sends a message of bytes over a frame-based serial control channel. Each frame carries one data byte and one active-low handshake bit driven by this side (`a_out`). Each frame also returns one active-low handshake bit from the peer (`e_in`). Outside logic handles the serial timing. It pulses `frame_stb` once per frame boundary, shows the peer bit received in the frame just ended on `e_in`, and sends whatever `a_out`/`d_out` hold for the next frame.

Bytes come in through a one-entry valid/ready intake. A byte is taken on any cycle with `s_valid && s_ready`. `s_ready` stays low while the intake register still holds a byte that has not been moved to the line. While `s_ready` is low, `s_valid` and `s_data` are ignored, so the producer must hold its byte until it sees `s_ready`. The processor raises `tx_en` to start a message. It drops `tx_en` after the last byte to end the message.

A new byte after the first is marked by one frame of inactive `a_out`. The peer confirms each byte by taking `e_in` from 1 to 0. Two idle `e_in` frames from the peer abort the transfer if they arrive after the peer has answered once and before the message has been closed. When the message is closed, they end it instead. There are two sticky interrupt flags, acknowledged and aborted. Each is cleared by writing one to its bit of `irq_clr`.

Top module: `mon_tx`

## Requirements
- R1: After reset `a_out` is 1, `tx_active` is 0, both interrupt flags are 0 and `s_ready` is 1.
- R2: A byte is taken when `s_valid && s_ready`. `s_ready` is then 0 until that byte moves to the line. `s_valid`/`s_data` presented while `s_ready` is 0 are ignored.
- R3: `a_out` and `d_out` change only in the cycle that follows a `frame_stb` cycle.
- R4: When idle, a strobe with `tx_en` = 1 and a byte held starts a transfer. After that strobe `a_out` = 0, `d_out` = the byte and `tx_active` = 1. A strobe with `tx_en` = 0 starts nothing.
- R5: While a byte awaits acknowledgement, a strobe with `e_in` = 0 whose previous strobe saw `e_in` = 1 sets `irq_ack` in the next cycle.
- R6: At that acknowledging strobe, if `tx_en` = 1 and a byte is held, `a_out` goes to 1 for exactly one frame with the new byte on `d_out`, then returns to 0.
- R7: A byte loaded through the intake while a byte awaits acknowledgement does not change `d_out`.
- R8: At an acknowledging strobe with `tx_en` = 0, `a_out` goes to 1 and `tx_active` stays 1. `tx_active` falls after the strobe that sees `e_in` = 1 for the second strobe in a row.
- R9: After the first acknowledgement of a transfer, two strobes in a row with `e_in` = 1 while `tx_en` = 1 set `irq_abort`, force `a_out` to 1 and clear `tx_active`. A single idle frame does not.
- R10: Before the first acknowledgement, idle `e_in` = 1 frames cause no abort.
- R11: Writing 1 to `irq_clr[0]` clears `irq_ack` and writing 1 to `irq_clr[1]` clears `irq_abort`. The flags otherwise stay set. When a set and a clear of the same flag fall in one cycle, the set wins.
- R12: After an acknowledgement with `tx_en` = 1 and no byte held, `a_out` stays 0 and `d_out` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Intake byte valid |
| s_ready | output | 1 | Intake register free |
| s_data | input | DATA_W | Intake byte |
| tx_en | input | 1 | Transmit enable control bit |
| frame_stb | input | 1 | One-cycle frame boundary strobe |
| e_in | input | 1 | Peer handshake bit of the frame just ended, active low |
| a_out | output | 1 | Handshake bit for the next frame, active low |
| d_out | output | DATA_W | Data byte for the next frame |
| tx_active | output | 1 | Transfer in progress |
| irq_ack | output | 1 | Sticky byte-acknowledged flag |
| irq_abort | output | 1 | Sticky abort flag |
| irq_clr | input | 2 | Write-one-to-clear strobes: bit 0 ack, bit 1 abort |

## Verification
Two events can land on the same cycle: an acknowledging frame strobe that raises `irq_ack`, and a processor clear strobe on `irq_clr[0]`. The bench provokes this on randomly chosen acknowledge frames of randomly sized messages. It expects the flag to read 1 afterwards, and it expects a later clear with no competing event to drop the flag. The acknowledging strobe can also coincide with the next byte being loaded into the line register. The bench judges that case by checking for the one-frame inactive `a_out` together with the new `d_out`, and it also checks that the intake becomes ready again.

// File: rtl/mon_tx_pkg.sv
package mon_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // no transfer, A inactive
    ST_SEND = 2'd1,  // A active, byte pending or waiting for the next
    ST_GAP  = 2'd2,  // one inactive A frame marking a new byte
    ST_END  = 2'd3   // A inactive, waiting for the peer to go idle
  } tx_state_e;

  localparam int IRQ_N   = 2;
  localparam int IRQ_ACK = 0;
  localparam int IRQ_ABT = 1;
endpackage

// File: rtl/mon_tx_hold.sv
module mon_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (s_valid && !hold_full) begin
      hold_full <= 1'b1;
      hold_data <= s_data;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  assign s_ready = !hold_full;
endmodule

// File: rtl/mon_tx_ehist.sv
module mon_tx_ehist (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_stb,
  input  logic e_in,
  output logic e_fall,
  output logic e_idle2
);
  logic e_prev;

  always_ff @(posedge clk) begin
    if (!rst_n)         e_prev <= 1'b1;
    else if (frame_stb) e_prev <= e_in;
  end

  // peer bit went active this frame / stayed inactive two frames in a row
  assign e_fall  = frame_stb && e_prev && !e_in;
  assign e_idle2 = frame_stb && e_prev && e_in;
endmodule

// File: rtl/mon_tx_irq.sv
module mon_tx_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/mon_tx.sv
module mon_tx
  import mon_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              tx_en,
  input  logic              frame_stb,
  input  logic              e_in,
  output logic              a_out,
  output logic [DATA_W-1:0] d_out,
  output logic              tx_active,
  output logic              irq_ack,
  output logic              irq_abort,
  input  logic [1:0]        irq_clr
);
  tx_state_e         state, st_n;
  logic              pending, pend_n;
  logic              e_seen, seen_n;
  logic              a_q, a_n;
  logic [DATA_W-1:0] d_q, d_n;
  logic              take, still_wait;
  logic              e_fall, e_idle2;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic [IRQ_N-1:0]  irq_set, irq_flag;

  mon_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .take(take), .hold_data(hold_data),
    .hold_full(hold_full)
  );

  mon_tx_ehist u_ehist (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .e_in(e_in),
    .e_fall(e_fall), .e_idle2(e_idle2)
  );

  mon_tx_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .flag(irq_flag)
  );

  always_comb begin
    st_n       = state;
    pend_n     = pending;
    seen_n     = e_seen;
    a_n        = a_q;
    d_n        = d_q;
    take       = 1'b0;
    still_wait = pending;
    irq_set    = '0;
    if (frame_stb) begin
      unique case (state)
        ST_IDLE: begin
          if (tx_en && hold_full) begin
            take   = 1'b1;
            d_n    = hold_data;
            a_n    = 1'b0;
            pend_n = 1'b1;
            seen_n = 1'b0;
            st_n   = ST_SEND;
          end
        end
        ST_SEND, ST_GAP: begin
          if (e_seen && e_idle2 && tx_en) begin
            irq_set[IRQ_ABT] = 1'b1;
            a_n    = 1'b1;
            pend_n = 1'b0;
            st_n   = ST_IDLE;
          end else if (state == ST_GAP) begin
            a_n  = 1'b0;
            st_n = ST_SEND;
          end else begin
            if (pending && e_fall) begin
              irq_set[IRQ_ACK] = 1'b1;
              seen_n     = 1'b1;
              still_wait = 1'b0;
            end
            pend_n = still_wait;
            if (!still_wait) begin
              if (tx_en && hold_full) begin
                take   = 1'b1;
                d_n    = hold_data;
                a_n    = 1'b1;
                pend_n = 1'b1;
                st_n   = ST_GAP;
              end else if (!tx_en) begin
                a_n  = 1'b1;
                st_n = ST_END;
              end
            end
          end
        end
        ST_END: begin
          if (e_idle2) st_n = ST_IDLE;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      e_seen  <= 1'b0;
      a_q     <= 1'b1;
      d_q     <= '0;
    end else begin
      state   <= st_n;
      pending <= pend_n;
      e_seen  <= seen_n;
      a_q     <= a_n;
      d_q     <= d_n;
    end
  end

  assign a_out     = a_q;
  assign d_out     = d_q;
  assign tx_active = (state != ST_IDLE);
  assign irq_ack   = irq_flag[IRQ_ACK];
  assign irq_abort = irq_flag[IRQ_ABT];
endmodule

// File: rtl/mon_tx_chk.sv
module mon_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              frame_stb,
  input logic              a_out,
  input logic [DATA_W-1:0] d_out,
  input logic              tx_active,
  input logic              irq_ack,
  input logic              irq_abort,
  input logic [1:0]        irq_clr
);
  AST_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_stb) |-> ($stable(a_out) && $stable(d_out))); // R3
  AST_INTAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s_valid && s_ready) |-> !s_ready); // R2
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_out && !$past(a_out)) |-> $stable(d_out)); // R7
  AST_IDLE_A_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> a_out); // R9
  AST_END_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) |-> $past(frame_stb)); // R8
  AST_ACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_ack) && !$past(irq_clr[0])) |-> irq_ack); // R11
  AST_ABT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_abort) && !$past(irq_clr[1])) |-> irq_abort); // R11
endmodule

bind mon_tx mon_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .frame_stb(frame_stb), .a_out(a_out), .d_out(d_out),
  .tx_active(tx_active), .irq_ack(irq_ack), .irq_abort(irq_abort),
  .irq_clr(irq_clr)
);

// File: tb/mon_tx_bench.sv
module mon_tx_bench;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              s_valid = 1'b0;
  logic              s_ready;
  logic [DATA_W-1:0] s_data = '0;
  logic              tx_en = 1'b0;
  logic              frame_stb = 1'b0;
  logic              e_in = 1'b1;
  logic              a_out;
  logic [DATA_W-1:0] d_out;
  logic              tx_active, irq_ack, irq_abort;
  logic [1:0]        irq_clr = 2'b00;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  mon_tx #(.DATA_W(DATA_W)) u_mon_tx (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .tx_en(tx_en), .frame_stb(frame_stb), .e_in(e_in),
    .a_out(a_out), .d_out(d_out), .tx_active(tx_active),
    .irq_ack(irq_ack), .irq_abort(irq_abort), .irq_clr(irq_clr)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R3 watchdog: actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // expected acknowledge from two successive peer samples
  function automatic logic exp_ack(input logic prev_e, input logic cur_e);
    return prev_e && !cur_e;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic e, input logic clr_ack);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    @(negedge clk);
    e_in = e;
    frame_stb = 1'b1;
    irq_clr = {1'b0, clr_ack};
    @(negedge clk);
    frame_stb = 1'b0;
    irq_clr = 2'b00;
  endtask

  task automatic push(input logic [DATA_W-1:0] b);
    @(negedge clk);
    check("R2 ready before push", s_ready, 1);
    s_valid = 1'b1;
    s_data = b;
    @(negedge clk);
    s_valid = 1'b0;
    check("R2 ready low after push", s_ready, 0);
  endtask

  task automatic clear(input logic [1:0] m);
    @(negedge clk);
    irq_clr = m;
    @(negedge clk);
    irq_clr = 2'b00;
  endtask

  initial begin
    logic [DATA_W-1:0] bytes [4];
    logic prev_e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 a_out", a_out, 1);
    check("R1 tx_active", tx_active, 0);
    check("R1 irq_ack", irq_ack, 0);
    check("R1 irq_abort", irq_abort, 0);
    check("R1 s_ready", s_ready, 1);

    // R2: intake ignores data while full
    push(8'hA5);
    @(negedge clk);
    s_valid = 1'b1;
    s_data = 8'h3C;
    repeat (2) @(negedge clk);
    s_valid = 1'b0;
    check("R2 still full", s_ready, 0);
    frame(1'b1, 1'b0);
    check("R4 no start without enable", tx_active, 0);
    check("R4 a idle without enable", a_out, 1);
    tx_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 no change without strobe", a_out, 1);
    frame(1'b1, 1'b0);
    check("R4 a active", a_out, 0);
    check("R2 first byte kept", d_out, 8'hA5);
    check("R4 active", tx_active, 1);
    check("R2 ready again", s_ready, 1);

    // R10: idle peer before first ack
    for (int i = 0; i < 3; i++) begin
      frame(1'b1, 1'b0);
      check("R10 no abort", irq_abort, 0);
      check("R10 still active", tx_active, 1);
    end

    // R5 / R12: ack with nothing queued
    frame(1'b0, 1'b0);
    check("R5 ack", irq_ack, 1);
    check("R12 a stays active", a_out, 0);
    frame(1'b0, 1'b0);
    check("R12 a stays active", a_out, 0);
    check("R12 data unchanged", d_out, 8'hA5);

    // R9: single idle frame, then two
    frame(1'b1, 1'b0);
    check("R9 single idle no abort", irq_abort, 0);
    check("R9 single idle active", tx_active, 1);
    frame(1'b1, 1'b0);
    check("R9 abort flag", irq_abort, 1);
    check("R9 a inactive", a_out, 1);
    check("R9 not active", tx_active, 0);
    tx_en = 1'b0;
    clear(2'b11);
    check("R11 ack cleared", irq_ack, 0);
    check("R11 abort cleared", irq_abort, 0);

    // constrained random messages
    prev_e = 1'b1;
    for (int m = 0; m < 25; m++) begin
      int n;
      n = $urandom_range(1, 4);
      for (int k = 0; k < 4; k++) bytes[k] = DATA_W'($urandom);
      push(bytes[0]);
      @(negedge clk);
      tx_en = 1'b1;
      frame(1'b1, 1'b0);
      prev_e = 1'b1;
      check("R4 start a", a_out, 0);
      check("R4 start data", d_out, bytes[0]);
      for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
        frame(1'b1, 1'b0);
        check("R10 idle peer", irq_abort, 0);
        check("R10 a held", a_out, 0);
      end
      for (int i = 0; i < n; i++) begin
        logic same;
        if (i < n - 1) begin
          push(bytes[i+1]);
          check("R7 data kept", d_out, bytes[i]);
        end else begin
          @(negedge clk);
          tx_en = 1'b0;
        end
        if (i > 0) begin
          frame(1'b1, 1'b0);
          check("R5 no ack on idle", irq_ack, 0);
          check("R9 single pulse no abort", tx_active, 1);
          prev_e = 1'b1;
        end
        same = 1'($urandom_range(0, 1));
        frame(1'b0, same);
        check("R5 ack raised", irq_ack, 32'(exp_ack(prev_e, 1'b0)));
        prev_e = 1'b0;
        if (i < n - 1) begin
          check("R6 gap a", a_out, 1);
          check("R6 gap data", d_out, bytes[i+1]);
          clear(2'b01);
          check("R11 ack cleared", irq_ack, 0);
          frame(1'b0, 1'b0);
          check("R6 a back active", a_out, 0);
          check("R6 data", d_out, bytes[i+1]);
        end else begin
          check("R8 a inactive", a_out, 1);
          check("R8 still active", tx_active, 1);
          clear(2'b01);
          check("R11 ack cleared", irq_ack, 0);
        end
      end
      if ($urandom_range(0, 1) == 1) begin
        frame(1'b0, 1'b0);
        check("R8 wait peer", tx_active, 1);
      end
      frame(1'b1, 1'b0);
      check("R8 one idle", tx_active, 1);
      frame(1'b1, 1'b0);
      check("R8 ended", tx_active, 0);
      check("R8 a idle", a_out, 1);
      check("R9 no abort at end", irq_abort, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule